// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. Its job is to bring any attached target that has lost track of the protocol back to a clean state. A target can get stuck this way after a reset in the middle of a transfer, for example while it is holding the data line low. A single-cycle request starts a fixed pattern on the bus:

1. A START.
2. Nine clock pulses with the data line released, so a target that is part-way through a byte can finish shifting it out.
3. A second START.
4. A STOP directly after that second START.

The block drives both lines only through active-high pull-low enables, which fits an open-drain pad. A `busy` level covers the whole pattern, and a one-cycle `done` marks its end.

Every phase length is a whole number of system clock cycles. The sequencer derives each length from a minimum time in nanoseconds and a clock-period parameter, rounding up. Two timing sets are built in: a standard set for the 400 kHz class of bus and a faster set for the 1 MHz class. The `fast_i` level picks between them and is captured when a request is accepted. The sequencer does not observe the bus: it does no arbitration and does not wait for a target that stretches the clock.

Top module: `bus_recover_seq`

## Requirements
- R1: After reset and whenever no sequence is running, `scl_oe_o`, `sda_oe_o`, `busy_o` and `done_o` are all 0, and nothing happens on the bus without a request.
- R2: An accepted request produces these events in this order, and no others:
  - a START (`sda_oe_o` rises while `scl_oe_o` is 0);
  - exactly nine SCL pulses (`scl_oe_o` 0→1→0);
  - a second START;
  - one STOP (`sda_oe_o` falls while `scl_oe_o` is 0).
- R3: SDA is released (`sda_oe_o`=0) in every SCL-high interval between the first START and the second START. `scl_oe_o` and `sda_oe_o` never change in the same cycle.
- R4: Each of the nine SCL-low intervals lasts ceil(t_low/T) cycles, where T is `CLK_PERIOD_NS`. Each SCL-high interval that ends in a clock fall lasts ceil(t_high/T) cycles. t_low/t_high is 1300/600 ns in standard mode and 400/400 ns in fast mode (130/60 and 40/40 cycles at 10 ns).
- R5: SCL first falls ceil(t_hold_start/T) cycles after the first START; t_hold_start is 600 ns standard, 250 ns fast. The second START comes ceil(t_high/T)+ceil(t_setup_start/T) cycles after the ninth SCL rise; t_setup_start is 600 ns standard, 250 ns fast (120 and 65 cycles).
- R6: The STOP follows the second START after ceil(max(t_hold_start, t_setup_stop)/T) cycles; t_setup_stop is 600 ns standard, 250 ns fast (60 and 25 cycles).
- R7: The bus stays free for ceil(t_free/T) cycles, where t_free is 1300 ns standard and 500 ns fast (130 and 50 cycles). This interval lies both between acceptance and the first START and between the STOP and `done_o`. `done_o` is high for exactly one cycle per sequence, in the cycle in which `busy_o` has just fallen.
- R8: `fast_i`=1 selects the fast set and 0 the standard set. The level is sampled in the cycle the request is accepted, and later changes have no effect on the running sequence.
- R9: A request that arrives while `busy_o` is 1 is ignored: no extra pulses, no second `done_o`, and no change to the running sequence.
- R10: `busy_o` rises on the clock edge that accepts a request. It stays high for the sum of all phase lengths: 2150 cycles in standard mode and 895 in fast mode at 10 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start request, accepted only while idle |
| fast_i | input | 1 | Timing set select: 1 = fast, 0 = standard |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence has ended |

## Verification
The sequencer is run once in each timing mode, which separates the two cycle-count sets in every phase length and in the total busy time. Both modes are then repeated while `fast_i` is toggled during the run and a second request is pulsed while busy. This shows whether the mode is captured only at acceptance and whether late requests are dropped. A reset in the middle of a sequence, followed by a quiet idle window, checks that the lines release at once and that nothing restarts on its own. A final run checks that the block still works normally afterwards.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

    // Width of every phase-length count, in clock cycles.
    localparam int DUR_W = 16;

    typedef logic [DUR_W-1:0] dur_t;

    // One cycle count for each kind of phase.
    typedef struct packed {
        dur_t low;         // SCL low time
        dur_t high;        // SCL high time
        dur_t start_hold;  // SDA low before the first SCL fall
        dur_t rs_setup;    // extra SCL-high time before the second START
        dur_t stop_hold;   // second START to STOP
        dur_t bus_free;    // idle bus before the first START and after the STOP
    } phase_set_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_START,
        PH_LOW,
        PH_HIGH,
        PH_RSETUP,
        PH_RSTART,
        PH_FREE
    } phase_e;

    // Round a time in nanoseconds up to a whole number of clock cycles.
    function automatic dur_t ns_to_cyc(input int unsigned ns, input int unsigned period);
        return dur_t'((ns + period - 1) / period);
    endfunction

endpackage

// File: rtl/bus_recover_timing.sv
module bus_recover_timing
    import bus_recover_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned STD_LOW_NS    = 1300,
    parameter int unsigned STD_HIGH_NS   = 600,
    parameter int unsigned STD_HDSTA_NS  = 600,
    parameter int unsigned STD_SUSTA_NS  = 600,
    parameter int unsigned STD_SUSTO_NS  = 600,
    parameter int unsigned STD_FREE_NS   = 1300,
    parameter int unsigned FST_LOW_NS    = 400,
    parameter int unsigned FST_HIGH_NS   = 400,
    parameter int unsigned FST_HDSTA_NS  = 250,
    parameter int unsigned FST_SUSTA_NS  = 250,
    parameter int unsigned FST_SUSTO_NS  = 250,
    parameter int unsigned FST_FREE_NS   = 500
) (
    input  logic       fast_i,
    output phase_set_t set_o
);

    // The STOP hold covers the longer of the start hold and the stop setup.
    localparam int unsigned STD_STOP_NS = (STD_HDSTA_NS > STD_SUSTO_NS) ? STD_HDSTA_NS : STD_SUSTO_NS;
    localparam int unsigned FST_STOP_NS = (FST_HDSTA_NS > FST_SUSTO_NS) ? FST_HDSTA_NS : FST_SUSTO_NS;

    localparam dur_t STD_LOW  = ns_to_cyc(STD_LOW_NS,   CLK_PERIOD_NS);
    localparam dur_t STD_HIGH = ns_to_cyc(STD_HIGH_NS,  CLK_PERIOD_NS);
    localparam dur_t STD_HD   = ns_to_cyc(STD_HDSTA_NS, CLK_PERIOD_NS);
    localparam dur_t STD_SU   = ns_to_cyc(STD_SUSTA_NS, CLK_PERIOD_NS);
    localparam dur_t STD_STOP = ns_to_cyc(STD_STOP_NS,  CLK_PERIOD_NS);
    localparam dur_t STD_FREE = ns_to_cyc(STD_FREE_NS,  CLK_PERIOD_NS);

    localparam dur_t FST_LOW  = ns_to_cyc(FST_LOW_NS,   CLK_PERIOD_NS);
    localparam dur_t FST_HIGH = ns_to_cyc(FST_HIGH_NS,  CLK_PERIOD_NS);
    localparam dur_t FST_HD   = ns_to_cyc(FST_HDSTA_NS, CLK_PERIOD_NS);
    localparam dur_t FST_SU   = ns_to_cyc(FST_SUSTA_NS, CLK_PERIOD_NS);
    localparam dur_t FST_STOP = ns_to_cyc(FST_STOP_NS,  CLK_PERIOD_NS);
    localparam dur_t FST_FREE = ns_to_cyc(FST_FREE_NS,  CLK_PERIOD_NS);

    always_comb begin
        if (fast_i) begin
            set_o.low        = FST_LOW;
            set_o.high       = FST_HIGH;
            set_o.start_hold = FST_HD;
            set_o.rs_setup   = FST_SU;
            set_o.stop_hold  = FST_STOP;
            set_o.bus_free   = FST_FREE;
        end else begin
            set_o.low        = STD_LOW;
            set_o.high       = STD_HIGH;
            set_o.start_hold = STD_HD;
            set_o.rs_setup   = STD_SU;
            set_o.stop_hold  = STD_STOP;
            set_o.bus_free   = STD_FREE;
        end
    end

endmodule

// File: rtl/bus_recover_timer.sv
module bus_recover_timer
    import bus_recover_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  dur_t load_val_i,
    output logic expired_o
);

    dur_t cnt_d, cnt_q;

    // A phase of N cycles loads N-1 and ends on the cycle the count reaches 0.
    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i - dur_t'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - dur_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TIMER_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
    import bus_recover_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned NUM_PULSES    = 9,
    parameter int unsigned STD_LOW_NS    = 1300,
    parameter int unsigned STD_HIGH_NS   = 600,
    parameter int unsigned STD_HDSTA_NS  = 600,
    parameter int unsigned STD_SUSTA_NS  = 600,
    parameter int unsigned STD_SUSTO_NS  = 600,
    parameter int unsigned STD_FREE_NS   = 1300,
    parameter int unsigned FST_LOW_NS    = 400,
    parameter int unsigned FST_HIGH_NS   = 400,
    parameter int unsigned FST_HDSTA_NS  = 250,
    parameter int unsigned FST_SUSTA_NS  = 250,
    parameter int unsigned FST_SUSTO_NS  = 250,
    parameter int unsigned FST_FREE_NS   = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic fast_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o
);

    localparam int PW = $clog2(NUM_PULSES + 1);
    localparam logic [PW-1:0] LAST_PULSE = PW'(NUM_PULSES);

    typedef struct packed {
        phase_e        st;
        logic [PW-1:0] pulses;
        logic          mode;
        logic          scl_oe;
        logic          sda_oe;
        logic          busy;
        logic          done;
    } seq_t;

    seq_t       q, d;
    phase_set_t set;
    logic       sel_fast;
    logic       tm_load;
    dur_t       tm_val;
    logic       tm_exp;

    // While idle the live input picks the set, so the first phase gets the
    // right length; after acceptance the captured mode is used.
    assign sel_fast = (q.st == PH_IDLE) ? fast_i : q.mode;

    bus_recover_timing #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .STD_LOW_NS    (STD_LOW_NS),
        .STD_HIGH_NS   (STD_HIGH_NS),
        .STD_HDSTA_NS  (STD_HDSTA_NS),
        .STD_SUSTA_NS  (STD_SUSTA_NS),
        .STD_SUSTO_NS  (STD_SUSTO_NS),
        .STD_FREE_NS   (STD_FREE_NS),
        .FST_LOW_NS    (FST_LOW_NS),
        .FST_HIGH_NS   (FST_HIGH_NS),
        .FST_HDSTA_NS  (FST_HDSTA_NS),
        .FST_SUSTA_NS  (FST_SUSTA_NS),
        .FST_SUSTO_NS  (FST_SUSTO_NS),
        .FST_FREE_NS   (FST_FREE_NS)
    ) u_timing (
        .fast_i (sel_fast),
        .set_o  (set)
    );

    bus_recover_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tm_load),
        .load_val_i (tm_val),
        .expired_o  (tm_exp)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        tm_load = 1'b0;
        tm_val  = set.low;
        unique case (q.st)
            PH_IDLE: begin
                if (req_i) begin
                    d.st    = PH_PRE;
                    d.busy  = 1'b1;
                    d.mode  = fast_i;
                    tm_load = 1'b1;
                    tm_val  = set.bus_free;
                end
            end
            PH_PRE: begin
                if (tm_exp) begin
                    d.st     = PH_START;
                    d.sda_oe = 1'b1;          // START: SDA falls, SCL released
                    tm_load  = 1'b1;
                    tm_val   = set.start_hold;
                end
            end
            PH_START: begin
                if (tm_exp) begin
                    d.st     = PH_LOW;
                    d.scl_oe = 1'b1;          // SDA keeps its level on this edge
                    tm_load  = 1'b1;
                    tm_val   = set.low;
                end
            end
            PH_LOW: begin
                d.sda_oe = 1'b0;              // let SDA go while SCL is held low
                if (tm_exp) begin
                    d.st     = PH_HIGH;
                    d.scl_oe = 1'b0;
                    d.pulses = q.pulses + PW'(1);
                    tm_load  = 1'b1;
                    tm_val   = set.high;
                end
            end
            PH_HIGH: begin
                if (tm_exp) begin
                    tm_load = 1'b1;
                    if (q.pulses == LAST_PULSE) begin
                        d.st   = PH_RSETUP;
                        tm_val = set.rs_setup;
                    end else begin
                        d.st     = PH_LOW;
                        d.scl_oe = 1'b1;
                        tm_val   = set.low;
                    end
                end
            end
            PH_RSETUP: begin
                if (tm_exp) begin
                    d.st     = PH_RSTART;
                    d.sda_oe = 1'b1;          // second START
                    tm_load  = 1'b1;
                    tm_val   = set.stop_hold;
                end
            end
            PH_RSTART: begin
                if (tm_exp) begin
                    d.st     = PH_FREE;
                    d.sda_oe = 1'b0;          // STOP
                    tm_load  = 1'b1;
                    tm_val   = set.bus_free;
                end
            end
            PH_FREE: begin
                if (tm_exp) begin
                    d.st     = PH_IDLE;
                    d.busy   = 1'b0;
                    d.done   = 1'b1;
                    d.pulses = '0;
                end
            end
            default: d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PH_IDLE, pulses: '0, mode: 1'b0, scl_oe: 1'b0,
                   sda_oe: 1'b0, busy: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_oe_o = q.scl_oe;
    assign sda_oe_o = q.sda_oe;
    assign busy_o   = q.busy;
    assign done_o   = q.done;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_IDLE) |-> (!q.scl_oe && !q.sda_oe && !q.busy)); // R1
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pulses <= LAST_PULSE)); // R2
    AST_EDGES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.scl_oe) |-> $stable(q.sda_oe)); // R3
    AST_SDA_FREE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_HIGH) |-> !q.sda_oe); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> $stable(q.mode)); // R8
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && req_i && q.st != PH_FREE) |=> q.busy); // R9

endmodule

// File: tb/bus_recover_seq_test.sv
module bus_recover_seq_test;

    logic clk    = 1'b0;
    logic rst_n  = 1'b0;
    logic req_i  = 1'b0;
    logic fast_i = 1'b0;
    logic scl_oe, sda_oe, busy, done;

    always #5 clk = ~clk;   // 100 MHz

    bus_recover_seq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .fast_i   (fast_i),
        .scl_oe_o (scl_oe),
        .sda_oe_o (sda_oe),
        .busy_o   (busy),
        .done_o   (done)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Stimulus and expected cycle counts at a 10 ns period.
    typedef struct packed {
        logic fast; logic flip; logic poke;
        int e_low; int e_high; int e_hold; int e_rs; int e_sto; int e_free; int e_total;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b0, 1'b0, 130, 60, 60, 120, 60, 130, 2150},
        '{1'b1, 1'b0, 1'b0,  40, 40, 25,  65, 25,  50,  895},
        '{1'b0, 1'b1, 1'b1, 130, 60, 60, 120, 60, 130, 2150},
        '{1'b1, 1'b1, 1'b1,  40, 40, 25,  65, 25,  50,  895}
    };

    // Bus monitor, sampled on falling edges.
    logic mon_on = 1'b0;
    logic p_scl = 1'b0, p_sda = 1'b0;
    int cyc, nfall, nstart, nstop, ndone, busy_c, bad_edge, bad_sda, stop_order;
    int min_low, max_low, min_high, max_high, hold_c, rs_c, sto_c, free_c, pre_c;
    int low_start, rise_at, start_at, stop_at, first_busy, run_len;

    task automatic clear_mon();
        cyc = 0; nfall = 0; nstart = 0; nstop = 0; ndone = 0; busy_c = 0;
        bad_edge = 0; bad_sda = 0; stop_order = 0;
        min_low = 1 << 30; max_low = 0; min_high = 1 << 30; max_high = 0;
        hold_c = 0; rs_c = 0; sto_c = 0; free_c = 0; pre_c = 0;
        low_start = 0; rise_at = 0; start_at = 0; stop_at = 0; first_busy = -1;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (busy) begin
                busy_c++;
                if (first_busy < 0) first_busy = cyc;
            end
            if (done) begin
                ndone++;
                free_c = cyc - stop_at;
            end
            if (scl_oe && !p_scl) begin
                nfall++;
                if (nfall == 1) hold_c = cyc - start_at;
                else begin
                    run_len = cyc - rise_at;
                    if (run_len < min_high) min_high = run_len;
                    if (run_len > max_high) max_high = run_len;
                end
                low_start = cyc;
            end
            if (!scl_oe && p_scl) begin
                run_len = cyc - low_start;
                if (run_len < min_low) min_low = run_len;
                if (run_len > max_low) max_low = run_len;
                rise_at = cyc;
            end
            if ((sda_oe != p_sda) && (scl_oe != p_scl)) bad_edge++;
            if (sda_oe && !p_sda && !scl_oe && !p_scl) begin
                nstart++;
                if (nstart == 1) pre_c = cyc - first_busy;
                if (nstart == 2) rs_c = cyc - rise_at;
                start_at = cyc;
            end
            if (!sda_oe && p_sda && !scl_oe && !p_scl) begin
                nstop++;
                stop_order = nstart;
                sto_c = cyc - start_at;
                stop_at = cyc;
            end
            if (!scl_oe && sda_oe && nfall >= 1 && nstart == 1) bad_sda++;
        end
        p_scl = scl_oe;
        p_sda = sda_oe;
    end

    task automatic run_one(input vec_t v);
        clear_mon();
        mon_on = 1'b1;
        @(negedge clk);
        fast_i = v.fast;
        req_i  = 1'b1;
        @(negedge clk);
        req_i  = 1'b0;
        if (v.flip) begin
            repeat (50) @(negedge clk);
            fast_i = ~v.fast;          // R8: late change must not matter
        end
        if (v.poke) begin
            repeat (200) @(negedge clk);
            req_i = 1'b1;              // R9: request while busy
            @(negedge clk);
            req_i = 1'b0;
        end
        for (int k = 0; k < 5000 && ndone == 0; k++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R2 scl pulses", nfall, 9);
        chk("R2 start count", nstart, 2);
        chk("R2 stop count", nstop, 1);
        chk("R2 stop after second start", stop_order, 2);
        chk("R3 edges coincide", bad_edge, 0);
        chk("R3 sda low during clocks", bad_sda, 0);
        chk("R4 min low", min_low, v.e_low);
        chk("R4 max low", max_low, v.e_low);
        chk("R4 min high", min_high, v.e_high);
        chk("R4 max high", max_high, v.e_high);
        chk("R5 start hold", hold_c, v.e_hold);
        chk("R5 repeated start setup", rs_c, v.e_rs);
        chk("R6 stop setup", sto_c, v.e_sto);
        chk("R7 free before start", pre_c, v.e_free);
        chk("R7 free after stop", free_c, v.e_free);
        chk("R7 done pulses", ndone, 1);
        chk("R10 busy length", busy_c, v.e_total);
        chk("R1 idle after run", int'({busy, scl_oe, sda_oe, done}), 0);
        if (v.poke) chk("R9 no second sequence", busy_c, v.e_total);
        mon_on = 1'b0;
        fast_i = 1'b0;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({busy, scl_oe, sda_oe, done}), 0);
        rst_n = 1'b1;
        clear_mon();
        mon_on = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 no activity unrequested", busy_c + nfall + nstart, 0);
        mon_on = 1'b0;

        for (int i = 0; i < 4; i++) run_one(VECS[i]);

        // R1: reset in the middle of a sequence releases the lines at once
        @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (500) @(negedge clk);
        chk("R1 busy mid run", int'(busy), 1);
        rst_n = 1'b0;
        #1;
        chk("R1 reset mid run", int'({busy, scl_oe, sda_oe, done}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_mon();
        mon_on = 1'b1;
        repeat (100) @(negedge clk);
        chk("R1 quiet after reset", busy_c + nfall + nstart + ndone, 0);
        mon_on = 1'b0;

        run_one(VECS[1]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule